// File: doc/BRIEF.md
# Virtual Function Routing ID Mapper

This block works out where the virtual functions of a physical function sit in the 8-bit device/function space, and checks that the layout fits. From the physical function's own device/function number, the offset to the first virtual function, the stride between them, the total count and a flag that says whether alternative routing IDs are in use, it can do three jobs. It can validate the whole layout. It can turn a virtual function index into a routing ID. It can turn an incoming routing ID back into an index, with a hit flag.

A request is presented with a one-cycle `start` while `busy` is low. The block answers with a one-cycle `done`, with the error, hit and result outputs valid in that cycle. Products and quotients are formed over several cycles by a shift-add multiplier and a restoring divider. All sums are kept 34 bits wide, so an out-of-range ID is flagged rather than wrapped back into range. Bus numbers and the storage of the configuration fields belong to the surrounding logic.

Top module: `vf_rid_mapper`

## Requirements
- R1: The first virtual function ID is `pf_rid + vf_offset`. Operation code 2 (ID to index) with `rid_in` equal to that sum returns hit=1, err=0 and index 0. The operation codes are: 0 validate, 1 index to ID, 2 ID to index, 3 reserved.
- R2: Operation 1 with `vf_index` below `num_vfs` and a result below 256 returns hit=1, err=0 and `rid_out = pf_rid + vf_offset + vf_index*vf_stride`.
- R3: Operation 0 computes the last ID as `pf_rid + vf_offset + vf_stride*(total_vfs-1)` with no wrap. If that value is 256 or more, err=1 and `rid_out`=0. Otherwise err=0 (unless R4 applies) and `rid_out` is the last ID. The hit output is 0 for every operation 0 result.
- R4: In operation 0 with `ari_en`=0, err=1 whenever bits 7:3 of the last ID differ from bits 7:3 of `pf_rid`. With `ari_en`=1 this comparison has no effect.
- R5: Operation 0 with `total_vfs`=0 returns err=0, hit=0 and `rid_out`=0, whatever the other fields are.
- R6: Operation 1 with `vf_index >= num_vfs` returns hit=0, err=0 and `rid_out`=0. An in-range index whose ID is 256 or more returns err=1, hit=0 and `rid_out`=0. Operations 0 and 1 always return `idx_out`=0.
- R7: Operation 2 returns hit=1 and `idx_out = (rid_in - first)/vf_stride` only when `rid_in` is at least the first ID (no wrap), the difference divides exactly by the stride, and the quotient is below `num_vfs`. Otherwise it returns hit=0 and `idx_out`=0. Operation 2 always returns err=0 and `rid_out`=0.
- R8: With `vf_stride`=0, operation 2 hits only when `rid_in` equals the first ID and `num_vfs` is nonzero, returning index 0. Operation 1 returns the first ID for any in-range index.
- R9: A `start` is taken only while `busy` is low, and a `start` during `busy` is ignored. Each request that is taken produces exactly one `done` pulse, one cycle wide. The result outputs hold their values until the next `done`.
- R10: Operation code 3 completes with err=1, hit=0, `rid_out`=0 and `idx_out`=0.
- R11: After reset, `busy`, `done`, `err` and `hit` are 0, and `rid_out` and `idx_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when busy is low |
| op | input | 2 | 0 validate, 1 index to ID, 2 ID to index, 3 reserved |
| pf_rid | input | 8 | Physical function device/function number |
| vf_offset | input | 16 | Distance from the physical function to the first virtual function |
| vf_stride | input | 16 | Distance between consecutive virtual functions |
| total_vfs | input | 16 | Number of virtual functions in the layout |
| num_vfs | input | 16 | Number of currently active virtual functions |
| ari_en | input | 1 | Alternative routing IDs present; lifts the device-number constraint |
| vf_index | input | 16 | Index for operation 1 |
| rid_in | input | 8 | Routing ID for operation 2 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Layout or range error |
| hit | output | 1 | Mapping found |
| rid_out | output | 8 | Resulting routing ID |
| idx_out | output | 16 | Resulting virtual function index |

## Verification
The validation path is tried with layouts that end exactly at 255 and at 256, with an offset that carries out of 16 bits, and with a stride product of 0x10000. This separates a true wide comparison from one that wraps. The same no-ARI layout is run with seven and eight functions, and again with the flag set, which shows the device-number check turning on and off. The reverse lookup gets an exact multiple, a value one off the grid, a value below the first ID, a quotient equal to the active count and a first ID past 255. Together these tell apart the remainder, ordering, count and wrap conditions. Stride-zero cases show that only index 0 can match, and a start issued while busy shows that the first request's result is the one returned.

// File: rtl/vf_rid_pkg.sv
package vf_rid_pkg;

    parameter int RID_W = 8;
    parameter int CNT_W = 16;
    parameter int DEV_LSB = 3;
    parameter int ACC_W = 2 * CNT_W + 2;

    typedef enum logic [1:0] {
        OP_CHECK  = 2'd0,
        OP_TO_RID = 2'd1,
        OP_TO_IDX = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIN  = 2'd3
    } st_e;

    typedef enum logic [1:0] {
        ACT_FIN = 2'd0,
        ACT_MUL = 2'd1,
        ACT_DIV = 2'd2
    } act_e;

    typedef struct packed {
        logic             err;
        logic             hit;
        logic [RID_W-1:0] rid;
        logic [CNT_W-1:0] idx;
    } res_t;

    function automatic logic f_past_space(input logic [ACC_W-1:0] id);
        return id >= ACC_W'(2 ** RID_W);
    endfunction

    function automatic logic f_dev_split(input logic [RID_W-1:DEV_LSB] pf_dev,
                                         input logic [ACC_W-1:0]       last_id);
        return last_id[RID_W-1:DEV_LSB] != pf_dev;
    endfunction

endpackage

// File: rtl/vf_rid_mul.sv
module vf_rid_mul #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           done,
    output logic [2*W-1:0] prod
);
    localparam int CW = $clog2(W);

    logic [2*W-1:0] mcand;
    logic [W-1:0]   mplier;
    logic [2*W-1:0] acc;
    logic [CW-1:0]  cnt;
    logic           run;
    logic [W-1:0]   a_q;
    logic [W-1:0]   b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            cnt    <= '0;
            run    <= 1'b0;
            done   <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                mcand  <= (2*W)'(a);
                mplier <= b;
                acc    <= '0;
                cnt    <= '0;
                run    <= 1'b1;
                a_q    <= a;
                b_q    <= b;
            end else if (run) begin
                if (mplier[0]) begin
                    acc <= acc + mcand;
                end
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                cnt    <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign prod = acc;

    // R2 and R3 rest on the iterated product matching the true product
    assert_mul_product_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (prod == ((2*W)'(a_q) * (2*W)'(b_q))));

endmodule

// File: rtl/vf_rid_div.sv
module vf_rid_div #(
    parameter int DVD_W = 8,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dvd,
    input  logic [DVS_W-1:0] dvs,
    output logic             done,
    output logic [DVD_W-1:0] quo,
    output logic [DVS_W-1:0] rem
);
    localparam int CW = $clog2(DVD_W);
    localparam int RW = DVD_W + DVS_W + 1;

    logic [DVD_W-1:0] dvd_sh;
    logic [DVS_W-1:0] dvs_q;
    logic [DVD_W-1:0] dvd_q;
    logic [CW-1:0]    cnt;
    logic             run;
    logic [DVS_W:0]   rem_sh;
    logic             take;

    assign rem_sh = {rem, dvd_sh[DVD_W-1]};
    assign take   = rem_sh >= {1'b0, dvs_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_sh <= '0;
            dvs_q  <= '0;
            dvd_q  <= '0;
            quo    <= '0;
            rem    <= '0;
            cnt    <= '0;
            run    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dvd_sh <= dvd;
                dvd_q  <= dvd;
                dvs_q  <= dvs;
                quo    <= '0;
                rem    <= '0;
                cnt    <= '0;
                run    <= 1'b1;
            end else if (run) begin
                rem    <= take ? DVS_W'(rem_sh - {1'b0, dvs_q}) : DVS_W'(rem_sh);
                quo    <= {quo[DVD_W-2:0], take};
                dvd_sh <= dvd_sh << 1;
                cnt    <= cnt + 1'b1;
                if (cnt == CW'(DVD_W - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    logic [RW-1:0] recon;
    assign recon = RW'(quo) * RW'(dvs_q) + RW'(rem);

    // R7: quotient and remainder reproduce the dividend exactly
    assert_div_identity_R7: assert property (@(posedge clk) disable iff (rst)
        (done && dvs_q != '0) |-> (recon == RW'(dvd_q) && rem < dvs_q));

endmodule

// File: rtl/vf_rid_mapper.sv
module vf_rid_mapper
    import vf_rid_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [RID_W-1:0] pf_rid,
    input  logic [CNT_W-1:0] vf_offset,
    input  logic [CNT_W-1:0] vf_stride,
    input  logic [CNT_W-1:0] total_vfs,
    input  logic [CNT_W-1:0] num_vfs,
    input  logic             ari_en,
    input  logic [CNT_W-1:0] vf_index,
    input  logic [RID_W-1:0] rid_in,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             hit,
    output logic [RID_W-1:0] rid_out,
    output logic [CNT_W-1:0] idx_out
);
    st_e              state;
    op_e              op_q;
    logic [ACC_W-1:0] first_q;
    logic [RID_W-1:DEV_LSB] dev_q;
    logic             ari_q;
    logic [CNT_W-1:0] num_q;
    res_t             res_q;

    // ---- dispatch of a new request ----
    logic             accept;
    logic [ACC_W-1:0] first_c;
    logic [ACC_W-1:0] rid_ext;
    act_e             act;
    res_t             imm;
    logic [CNT_W-1:0] mul_b;
    logic [RID_W-1:0] div_dvd;

    assign accept  = start && (state == ST_IDLE);
    assign first_c = ACC_W'(pf_rid) + ACC_W'(vf_offset);
    assign rid_ext = ACC_W'(rid_in);

    always_comb begin
        act     = ACT_FIN;
        imm     = '0;
        mul_b   = vf_index;
        div_dvd = rid_in - first_c[RID_W-1:0];
        case (op_e'(op))
            OP_CHECK: begin
                if (total_vfs != '0) begin
                    act   = ACT_MUL;
                    mul_b = total_vfs - 1'b1;
                end
            end
            OP_TO_RID: begin
                if (vf_index < num_vfs) begin
                    act = ACT_MUL;
                end
            end
            OP_TO_IDX: begin
                if (rid_ext >= first_c) begin
                    if (vf_stride == '0) begin
                        imm.hit = (rid_ext == first_c) && (num_vfs != '0);
                    end else begin
                        act = ACT_DIV;
                    end
                end
            end
            default: imm.err = 1'b1;
        endcase
    end

    // ---- arithmetic engines ----
    logic               mul_done;
    logic [2*CNT_W-1:0] mul_prod;
    logic               div_done;
    logic [RID_W-1:0]   div_quo;
    logic [CNT_W-1:0]   div_rem;

    vf_rid_mul #(.W(CNT_W)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .start(accept && act == ACT_MUL),
        .a    (vf_stride),
        .b    (mul_b),
        .done (mul_done),
        .prod (mul_prod)
    );

    vf_rid_div #(.DVD_W(RID_W), .DVS_W(CNT_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .start(accept && act == ACT_DIV),
        .dvd  (div_dvd),
        .dvs  (vf_stride),
        .done (div_done),
        .quo  (div_quo),
        .rem  (div_rem)
    );

    // ---- result formation ----
    logic [ACC_W-1:0] sum;
    res_t             fin_mul;
    res_t             fin_div;

    assign sum = first_q + ACC_W'(mul_prod);

    always_comb begin
        fin_mul = '0;
        if (op_q == OP_CHECK) begin
            fin_mul.err = f_past_space(sum) || (!ari_q && f_dev_split(dev_q, sum));
        end else begin
            fin_mul.err = f_past_space(sum);
            fin_mul.hit = !f_past_space(sum);
        end
        fin_mul.rid = fin_mul.err ? '0 : sum[RID_W-1:0];
    end

    always_comb begin
        fin_div     = '0;
        fin_div.hit = (div_rem == '0) && (CNT_W'(div_quo) < num_q);
        fin_div.idx = fin_div.hit ? CNT_W'(div_quo) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= OP_CHECK;
            first_q <= '0;
            dev_q   <= '0;
            ari_q   <= 1'b0;
            num_q   <= '0;
            res_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q    <= op_e'(op);
                        first_q <= first_c;
                        dev_q   <= pf_rid[RID_W-1:DEV_LSB];
                        ari_q   <= ari_en;
                        num_q   <= num_vfs;
                        case (act)
                            ACT_MUL: state <= ST_MUL;
                            ACT_DIV: state <= ST_DIV;
                            default: begin
                                res_q <= imm;
                                state <= ST_FIN;
                            end
                        endcase
                    end
                end
                ST_MUL: begin
                    if (mul_done) begin
                        res_q <= fin_mul;
                        state <= ST_FIN;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        res_q <= fin_div;
                        state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_FIN);
    assign err     = res_q.err;
    assign hit     = res_q.hit;
    assign rid_out = res_q.rid;
    assign idx_out = res_q.idx;

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: an accepted request makes the block busy
    assert_busy_on_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R6: a result never reports a hit and an error together
    assert_hit_err_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !(hit && err));

    // R5: an empty layout validates without error right away
    assert_empty_layout_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 2'd0 && total_vfs == '0) |=> (done && !err));

    // R7: a reverse hit always names an active function
    assert_idx_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (done && hit && op_q == OP_TO_IDX) |-> (idx_out < num_q));

    // R2: a forward hit never lies below the first function
    assert_rid_floor_R2: assert property (@(posedge clk) disable iff (rst)
        (done && hit && op_q == OP_TO_RID) |-> (ACC_W'(rid_out) >= first_q));

endmodule

// File: tb/vf_rid_mapper_bench.sv
module vf_rid_mapper_bench;

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  op;
        logic [7:0]  pf;
        logic [15:0] off;
        logic [15:0] str;
        logic [15:0] tot;
        logic [15:0] num;
        logic        ari;
        logic [15:0] idx;
        logic [7:0]  rin;
        logic        e_err;
        logic        e_hit;
        logic [7:0]  e_rid;
        logic [15:0] e_idx;
    } vec_t;

    localparam int NV = 24;

    // req, op, pf, off, stride, total, num, ari, idx, rid_in, err, hit, rid, idx
    localparam vec_t VECS [NV] = '{
        '{8'd1,  2'd2, 8'h10, 16'd4,     16'd2,     16'd8,     16'd8,  1'b0, 16'd0, 8'h14, 1'b0, 1'b1, 8'h00, 16'd0},  // R1 first ID
        '{8'd2,  2'd1, 8'h10, 16'd4,     16'd2,     16'd8,     16'd8,  1'b0, 16'd5, 8'h00, 1'b0, 1'b1, 8'h1E, 16'd0},  // R2
        '{8'd2,  2'd1, 8'h08, 16'd1,     16'd3,     16'd8,     16'd8,  1'b0, 16'd6, 8'h00, 1'b0, 1'b1, 8'h1B, 16'd0},  // R2
        '{8'd3,  2'd0, 8'h00, 16'd1,     16'd1,     16'd255,   16'd0,  1'b1, 16'd0, 8'h00, 1'b0, 1'b0, 8'hFF, 16'd0},  // R3 ends at 255
        '{8'd3,  2'd0, 8'h00, 16'd1,     16'd1,     16'd256,   16'd0,  1'b1, 16'd0, 8'h00, 1'b1, 1'b0, 8'h00, 16'd0},  // R3 ends at 256
        '{8'd3,  2'd0, 8'h80, 16'hFF80,  16'd1,     16'd1,     16'd0,  1'b1, 16'd0, 8'h00, 1'b1, 1'b0, 8'h00, 16'd0},  // R3 offset carry
        '{8'd3,  2'd0, 8'h00, 16'd0,     16'h0100,  16'h0101,  16'd0,  1'b1, 16'd0, 8'h00, 1'b1, 1'b0, 8'h00, 16'd0},  // R3 product 0x10000
        '{8'd4,  2'd0, 8'h08, 16'd1,     16'd1,     16'd7,     16'd0,  1'b0, 16'd0, 8'h00, 1'b0, 1'b0, 8'h0F, 16'd0},  // R4 same device
        '{8'd4,  2'd0, 8'h08, 16'd1,     16'd1,     16'd8,     16'd0,  1'b0, 16'd0, 8'h00, 1'b1, 1'b0, 8'h00, 16'd0},  // R4 device split
        '{8'd4,  2'd0, 8'h08, 16'd1,     16'd1,     16'd8,     16'd0,  1'b1, 16'd0, 8'h00, 1'b0, 1'b0, 8'h10, 16'd0},  // R4 flag lifts it
        '{8'd5,  2'd0, 8'hF8, 16'hFFFF,  16'hFFFF,  16'd0,     16'd0,  1'b0, 16'd0, 8'h00, 1'b0, 1'b0, 8'h00, 16'd0},  // R5 empty
        '{8'd6,  2'd1, 8'h10, 16'd4,     16'd2,     16'd8,     16'd8,  1'b0, 16'd8, 8'h00, 1'b0, 1'b0, 8'h00, 16'd0},  // R6 index = count
        '{8'd6,  2'd1, 8'hF0, 16'h0010,  16'd1,     16'd8,     16'd8,  1'b0, 16'd3, 8'h00, 1'b1, 1'b0, 8'h00, 16'd0},  // R6 past 255
        '{8'd7,  2'd2, 8'h10, 16'd4,     16'd2,     16'd8,     16'd8,  1'b0, 16'd0, 8'h1A, 1'b0, 1'b1, 8'h00, 16'd3},  // R7 exact
        '{8'd7,  2'd2, 8'h10, 16'd4,     16'd2,     16'd8,     16'd8,  1'b0, 16'd0, 8'h1B, 1'b0, 1'b0, 8'h00, 16'd0},  // R7 off grid
        '{8'd7,  2'd2, 8'h10, 16'd4,     16'd2,     16'd8,     16'd8,  1'b0, 16'd0, 8'h13, 1'b0, 1'b0, 8'h00, 16'd0},  // R7 below first
        '{8'd7,  2'd2, 8'h10, 16'd4,     16'd2,     16'd8,     16'd8,  1'b0, 16'd0, 8'h24, 1'b0, 1'b0, 8'h00, 16'd0},  // R7 quotient = count
        '{8'd7,  2'd2, 8'h00, 16'd1,     16'd3,     16'd20,    16'd20, 1'b0, 16'd0, 8'h3A, 1'b0, 1'b1, 8'h00, 16'd19}, // R7 last active
        '{8'd8,  2'd2, 8'h20, 16'd2,     16'd0,     16'd4,     16'd4,  1'b0, 16'd0, 8'h22, 1'b0, 1'b1, 8'h00, 16'd0},  // R8 zero stride hit
        '{8'd8,  2'd2, 8'h20, 16'd2,     16'd0,     16'd4,     16'd4,  1'b0, 16'd0, 8'h23, 1'b0, 1'b0, 8'h00, 16'd0},  // R8 zero stride miss
        '{8'd8,  2'd1, 8'h20, 16'd2,     16'd0,     16'd4,     16'd4,  1'b0, 16'd3, 8'h00, 1'b0, 1'b1, 8'h22, 16'd0},  // R8 forward
        '{8'd8,  2'd2, 8'h20, 16'd2,     16'd0,     16'd4,     16'd0,  1'b0, 16'd0, 8'h22, 1'b0, 1'b0, 8'h00, 16'd0},  // R8 no active
        '{8'd10, 2'd3, 8'h00, 16'd0,     16'd0,     16'd0,     16'd0,  1'b0, 16'd0, 8'h00, 1'b1, 1'b0, 8'h00, 16'd0},  // R10 reserved
        '{8'd7,  2'd2, 8'h80, 16'hFF80,  16'd1,     16'd1,     16'd1,  1'b0, 16'd0, 8'h00, 1'b0, 1'b0, 8'h00, 16'd0}   // R7 first past 255
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [7:0]  pf_rid = '0;
    logic [15:0] vf_offset = '0;
    logic [15:0] vf_stride = '0;
    logic [15:0] total_vfs = '0;
    logic [15:0] num_vfs = '0;
    logic        ari_en = 1'b0;
    logic [15:0] vf_index = '0;
    logic [7:0]  rid_in = '0;
    logic        busy;
    logic        done;
    logic        err;
    logic        hit;
    logic [7:0]  rid_out;
    logic [15:0] idx_out;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    vf_rid_mapper u_vf_rid_mapper (
        .clk(clk), .rst(rst), .start(start), .op(op), .pf_rid(pf_rid),
        .vf_offset(vf_offset), .vf_stride(vf_stride), .total_vfs(total_vfs),
        .num_vfs(num_vfs), .ari_en(ari_en), .vf_index(vf_index), .rid_in(rid_in),
        .busy(busy), .done(done), .err(err), .hit(hit), .rid_out(rid_out),
        .idx_out(idx_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op        = v.op;
        pf_rid    = v.pf;
        vf_offset = v.off;
        vf_stride = v.str;
        total_vfs = v.tot;
        num_vfs   = v.num;
        ari_en    = v.ari;
        vf_index  = v.idx;
        rid_in    = v.rin;
    endtask

    // waits at falling edges for done; returns number of edges waited
    task automatic wait_done(output int waited);
        waited = 0;
        while (done !== 1'b1 && waited < 200) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic run_vec(input vec_t v, input int k);
        int w;
        string tag;
        tag = $sformatf("R%0d vec%0d", v.req, k);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(w);
        check({tag, " done"}, {31'd0, done}, 32'd1);
        check({tag, " err"},  {31'd0, err},  {31'd0, v.e_err});
        check({tag, " hit"},  {31'd0, hit},  {31'd0, v.e_hit});
        check({tag, " rid"},  {24'd0, rid_out}, {24'd0, v.e_rid});
        check({tag, " idx"},  {16'd0, idx_out}, {16'd0, v.e_idx});
    endtask

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check("R11 busy", {31'd0, busy}, 32'd0);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 err",  {31'd0, err},  32'd0);
        check("R11 hit",  {31'd0, hit},  32'd0);
        check("R11 rid",  {24'd0, rid_out}, 32'd0);
        check("R11 idx",  {16'd0, idx_out}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k], k);
        end

        // R9: done lasts one cycle and results hold afterwards
        run_vec(VECS[1], 100);
        @(negedge clk);
        check("R9 done width", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        check("R9 hold rid", {24'd0, rid_out}, 32'h1E);
        check("R9 hold hit", {31'd0, hit}, 32'd1);
        check("R9 idle busy", {31'd0, busy}, 32'd0);

        // R9: a start during busy is ignored
        @(negedge clk);
        drive(VECS[2]);
        start = 1'b1;
        @(negedge clk);
        drive(VECS[22]);
        check("R9 busy after accept", {31'd0, busy}, 32'd1);
        @(negedge clk);
        start = 1'b0;
        wait_done(w);
        check("R9 first result rid", {24'd0, rid_out}, 32'h1B);
        check("R9 first result err", {31'd0, err}, 32'd0);
        begin
            int extra = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (done === 1'b1) extra++;
            end
            check("R9 single done", extra, 32'd0);
        end

        // R5: empty layout answers without the multiplier
        @(negedge clk);
        drive(VECS[10]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R5 immediate done", {31'd0, done}, 32'd1);
        check("R5 immediate err", {31'd0, err}, 32'd0);

        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule